// File: doc/BRIEF.md
# PC Card I/O Window Decoder

This block decides whether a 16-bit host I/O address falls inside one of two programmable I/O windows of a PC card socket. For each address presented with a valid strobe it produces, one clock later, a hit flag, the number of the window that matched, and the transfer attributes of that window. The attributes are the data width, where the 16-bit select comes from, and the wait-state request.

Software sets up the windows through an indexed byte register port: an index byte picks a register, and a data byte is written to it or read back from it. Every window has an inclusive start address and an inclusive stop address. One control byte holds the attribute nibbles of both windows, and one enable byte switches each window on or off. Turning a window off erases its address range. Turning a window on while its attribute nibble is blank loads a default set of attributes. Generating the card-side I/O cycle and routing interrupts are handled by other blocks.

Top module: `pcio_window_decoder`

## Requirements
- R1: Window w (w = 0 or 1) keeps its start address at index 0x08+4w (low byte) and 0x09+4w (high byte), and its stop address at 0x0A+4w (low byte) and 0x0B+4w (high byte). Each byte is written when cfg_we is high and reads back on cfg_rdata in the same cycle that its index is presented.
- R2: An enabled window matches an address when start <= address <= stop. Both limits are inclusive.
- R3: The enable byte sits at index 0x06. Bit 6 enables window 0 and bit 7 enables window 1, and the other bits read as zero. A disabled window never produces a hit.
- R4: A write that moves a window's enable bit from 1 to 0 sets that window's start and stop registers to zero.
- R5: A write that moves a window's enable bit from 0 to 1 while that window's attribute nibble is 0 loads the nibble with 4'b1011. This means 16-bit data, select driven by the card, and wait-state insertion.
- R6: The control byte sits at index 0x07. Window 0's nibble is bits 3:0 and window 1's nibble is bits 7:4. Within a nibble, bit 0 is 16-bit data, bit 1 is select driven by the card, bit 2 is zero wait state, and bit 3 is wait-state insertion. Loading the default into one window's nibble leaves the other nibble unchanged.
- R7: When both windows match the same address, window 0 is reported.
- R8: The outputs are registered. They show the result for the address presented with addr_vld one rising edge earlier. When addr_vld is low or no window matches, hit, hit_win, hit_wide, hit_card_cs and hit_wait are all 0.
- R9: hit_wait is 2'b01 when only the zero-wait bit is set, 2'b10 when the wait-insertion bit is set (whether or not zero wait is also set), and 2'b00 when neither is set.
- R10: On a hit, hit_wide equals bit 0 and hit_card_cs equals bit 1 of the matching window's nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 8 | Register index |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read data for the register at cfg_idx |
| addr_vld | input | 1 | Host I/O address is valid |
| addr | input | 16 | Host I/O address |
| hit | output | 1 | Address fell inside an enabled window |
| hit_win | output | 1 | Number of the matching window |
| hit_wide | output | 1 | Matching window uses 16-bit data |
| hit_card_cs | output | 1 | The card drives the 16-bit select |
| hit_wait | output | 2 | Wait request: 00 normal, 01 zero wait, 10 extra wait |

## Verification
Assertions check the following on every cycle: that turning a window off empties its range, that turning it on with a blank nibble loads the default, that an enable write leaves the other window's nibble alone, that window 0 wins when both match, that a cycle without a strobe gives a silent output, and that the wait code never takes its unused value. The bench scenarios are what show the rest. The inclusive edges of each range, the address ranges themselves, the mapping from each nibble to its attribute outputs, and the full sequence of disabling, reprogramming and re-enabling can only be seen through the register port.

// File: rtl/pciow_pkg.sv
package pciow_pkg;
  localparam int NWIN = 2;
  localparam int NIB_W = 4;

  typedef struct packed {
    logic wait_ins;
    logic zero_ws;
    logic card_cs;
    logic data16;
  } io_flags_t;

  localparam io_flags_t FLAGS_DEFAULT = '{wait_ins: 1'b1, zero_ws: 1'b0, card_cs: 1'b1, data16: 1'b1};

  typedef enum logic [1:0] {
    WAIT_NORMAL = 2'b00,
    WAIT_ZERO   = 2'b01,
    WAIT_EXTRA  = 2'b10
  } wait_code_e;

  function automatic logic in_window(input logic [15:0] a, input logic [15:0] lo,
                                     input logic [15:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic wait_code_e resolve_wait(input io_flags_t f);
    if (f.wait_ins) return WAIT_EXTRA;
    if (f.zero_ws) return WAIT_ZERO;
    return WAIT_NORMAL;
  endfunction
endpackage

// File: rtl/pciow_regs.sv
module pciow_regs
  import pciow_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W = 8,
  parameter logic [7:0] IDX_ENABLE = 8'h06,
  parameter logic [7:0] IDX_CTRL = 8'h07,
  parameter logic [7:0] IDX_WIN_BASE = 8'h08,
  parameter int EN_BIT_LO = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  output logic [NWIN-1:0] win_en,
  output logic [NWIN-1:0][ADDR_W-1:0] win_lo,
  output logic [NWIN-1:0][ADDR_W-1:0] win_hi,
  output io_flags_t [NWIN-1:0] win_flags
);
  localparam int AB = (ADDR_W + 7) / 8;
  localparam int STRIDE = 2 * AB;

  logic [NWIN-1:0] en_q;
  logic [7:0] ctrl_q;
  logic [NWIN-1:0][AB*8-1:0] lo_q;
  logic [NWIN-1:0][AB*8-1:0] hi_q;

  logic sel_en, sel_ctrl;
  logic [NWIN-1:0] rise_w, fall_w;

  assign sel_en = cfg_we && (cfg_idx == IDX_W'(IDX_ENABLE));
  assign sel_ctrl = cfg_we && (cfg_idx == IDX_W'(IDX_CTRL));

  for (genvar w = 0; w < NWIN; w++) begin : g_evt
    assign rise_w[w] = sel_en && !en_q[w] && cfg_wdata[EN_BIT_LO+w];
    assign fall_w[w] = sel_en && en_q[w] && !cfg_wdata[EN_BIT_LO+w];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      ctrl_q <= '0;
      lo_q <= '0;
      hi_q <= '0;
    end else if (cfg_we) begin
      if (sel_ctrl) ctrl_q <= cfg_wdata;
      for (int w = 0; w < NWIN; w++) begin
        for (int k = 0; k < AB; k++) begin
          if (cfg_idx == IDX_W'(int'(IDX_WIN_BASE) + STRIDE*w + k))
            lo_q[w][8*k +: 8] <= cfg_wdata;
          if (cfg_idx == IDX_W'(int'(IDX_WIN_BASE) + STRIDE*w + AB + k))
            hi_q[w][8*k +: 8] <= cfg_wdata;
        end
        if (sel_en) en_q[w] <= cfg_wdata[EN_BIT_LO+w];
        if (fall_w[w]) begin
          lo_q[w] <= '0;
          hi_q[w] <= '0;
        end
        if (rise_w[w] && ctrl_q[NIB_W*w +: NIB_W] == '0)
          ctrl_q[NIB_W*w +: NIB_W] <= FLAGS_DEFAULT;
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_idx == IDX_W'(IDX_ENABLE)) begin
      for (int w = 0; w < NWIN; w++) cfg_rdata[EN_BIT_LO+w] = en_q[w];
    end
    if (cfg_idx == IDX_W'(IDX_CTRL)) cfg_rdata = ctrl_q;
    for (int w = 0; w < NWIN; w++) begin
      for (int k = 0; k < AB; k++) begin
        if (cfg_idx == IDX_W'(int'(IDX_WIN_BASE) + STRIDE*w + k))
          cfg_rdata = lo_q[w][8*k +: 8];
        if (cfg_idx == IDX_W'(int'(IDX_WIN_BASE) + STRIDE*w + AB + k))
          cfg_rdata = hi_q[w][8*k +: 8];
      end
    end
  end

  assign win_en = en_q;
  for (genvar w = 0; w < NWIN; w++) begin : g_out
    assign win_lo[w] = lo_q[w][ADDR_W-1:0];
    assign win_hi[w] = hi_q[w][ADDR_W-1:0];
    assign win_flags[w] = io_flags_t'(ctrl_q[NIB_W*w +: NIB_W]);

    // R4: switching a window off leaves an empty range
    assert_clear_on_disable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fall_w[w] |=> (win_lo[w] == '0) && (win_hi[w] == '0) && !win_en[w]);
    // R5: switching on with a blank nibble loads the default attributes
    assert_default_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_w[w] && win_flags[w] == '0) |=> (win_flags[w] == FLAGS_DEFAULT) && win_en[w]);
    // R6: an enable write that does not activate this window keeps its nibble
    assert_nibble_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_en && !rise_w[w]) |=> $stable(win_flags[w]));
  end
endmodule

// File: rtl/pciow_match.sv
module pciow_match
  import pciow_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [ADDR_W-1:0] addr,
  output logic match
);
  assign match = en && in_window(16'(addr), 16'(lo), 16'(hi));

  // R3: a disabled window never matches
  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !match);
endmodule

// File: rtl/pciow_select.sv
module pciow_select
  import pciow_pkg::*;
#(
  parameter int WIN_IDX_W = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_vld,
  input  logic [NWIN-1:0] match,
  input  io_flags_t [NWIN-1:0] flags,
  output logic hit,
  output logic [WIN_IDX_W-1:0] hit_win,
  output logic hit_wide,
  output logic hit_card_cs,
  output logic [1:0] hit_wait
);
  logic found;
  logic [WIN_IDX_W-1:0] pick;
  io_flags_t pick_flags;

  always_comb begin
    found = 1'b0;
    pick = '0;
    pick_flags = '0;
    for (int w = NWIN - 1; w >= 0; w--) begin
      if (match[w]) begin
        found = 1'b1;
        pick = WIN_IDX_W'(w);
        pick_flags = flags[w];
      end
    end
  end

  logic take;
  assign take = addr_vld && found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit <= 1'b0;
      hit_win <= '0;
      hit_wide <= 1'b0;
      hit_card_cs <= 1'b0;
      hit_wait <= WAIT_NORMAL;
    end else begin
      hit <= take;
      hit_win <= take ? pick : '0;
      hit_wide <= take && pick_flags.data16;
      hit_card_cs <= take && pick_flags.card_cs;
      hit_wait <= take ? resolve_wait(pick_flags) : WAIT_NORMAL;
    end
  end

  // R7: window 0 wins whenever it matches a strobed address
  assert_low_window_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && match[0]) |=> hit && (hit_win == '0));
  // R8: no strobe, no result
  assert_idle_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> !hit && !hit_wide && !hit_card_cs && (hit_wait == 2'b00) && (hit_win == '0));
  // R9: the unused wait code never appears
  assert_wait_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_wait != 2'b11);
endmodule

// File: rtl/pcio_window_decoder.sv
module pcio_window_decoder
  import pciow_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W = 8,
  parameter logic [7:0] IDX_ENABLE = 8'h06,
  parameter logic [7:0] IDX_CTRL = 8'h07,
  parameter logic [7:0] IDX_WIN_BASE = 8'h08,
  parameter int EN_BIT_LO = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic addr_vld,
  input  logic [ADDR_W-1:0] addr,
  output logic hit,
  output logic [$clog2(NWIN)-1:0] hit_win,
  output logic hit_wide,
  output logic hit_card_cs,
  output logic [1:0] hit_wait
);
  localparam int WIN_IDX_W = $clog2(NWIN);

  logic [NWIN-1:0] win_en;
  logic [NWIN-1:0][ADDR_W-1:0] win_lo;
  logic [NWIN-1:0][ADDR_W-1:0] win_hi;
  io_flags_t [NWIN-1:0] win_flags;
  logic [NWIN-1:0] win_match;

  pciow_regs #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDX_ENABLE(IDX_ENABLE),
    .IDX_CTRL(IDX_CTRL), .IDX_WIN_BASE(IDX_WIN_BASE), .EN_BIT_LO(EN_BIT_LO)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .win_en(win_en),
    .win_lo(win_lo), .win_hi(win_hi), .win_flags(win_flags)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    pciow_match #(.ADDR_W(ADDR_W)) u_match (
      .clk(clk), .rst_n(rst_n), .en(win_en[w]), .lo(win_lo[w]),
      .hi(win_hi[w]), .addr(addr), .match(win_match[w])
    );
  end

  pciow_select #(.WIN_IDX_W(WIN_IDX_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .match(win_match),
    .flags(win_flags), .hit(hit), .hit_win(hit_win), .hit_wide(hit_wide),
    .hit_card_cs(hit_card_cs), .hit_wait(hit_wait)
  );

  // R2: a strobed address that lies inside enabled window 1 but outside window 0 hits window 1
  assert_inclusive_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && win_en[1] && addr >= win_hi[1] - win_hi[1] + win_lo[1] && addr <= win_hi[1]
     && !win_match[0]) |=> hit && (hit_win == WIN_IDX_W'(1)));
endmodule

// File: tb/sim_pcio_window_decoder.sv
`timescale 1ns/1ps
module sim_pcio_window_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_idx = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic addr_vld = 1'b0;
  logic [15:0] addr = '0;
  logic hit, hit_win, hit_wide, hit_card_cs;
  logic [1:0] hit_wait;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pcio_window_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .addr_vld(addr_vld),
    .addr(addr), .hit(hit), .hit_win(hit_win), .hit_wide(hit_wide),
    .hit_card_cs(hit_card_cs), .hit_wait(hit_wait)
  );

  // {addr, hit, win, wide, card_cs, wait}
  localparam logic [21:0] VEC [8] = '{
    {16'h02FF, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00},
    {16'h0300, 1'b1, 1'b0, 1'b1, 1'b0, 2'b01},
    {16'h031F, 1'b1, 1'b0, 1'b1, 1'b0, 2'b01},
    {16'h0310, 1'b1, 1'b0, 1'b1, 1'b0, 2'b01},
    {16'h0320, 1'b1, 1'b1, 1'b0, 1'b1, 2'b10},
    {16'h03FF, 1'b1, 1'b1, 1'b0, 1'b1, 2'b10},
    {16'h0400, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00},
    {16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] idx, output logic [7:0] data);
    @(negedge clk);
    cfg_idx = idx;
    #1 data = cfg_rdata;
  endtask

  task automatic look(input logic [15:0] a, input logic vld);
    @(negedge clk);
    addr = a; addr_vld = vld;
    @(negedge clk);
    addr_vld = 1'b0;
  endtask

  task automatic set_window(input int w, input logic [15:0] lo, input logic [15:0] hi);
    wr(8'(8 + 4*w), lo[7:0]);
    wr(8'(9 + 4*w), lo[15:8]);
    wr(8'(10 + 4*w), hi[7:0]);
    wr(8'(11 + 4*w), hi[15:8]);
  endtask

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    // reset state
    chk("R8 reset hit", 32'(hit), 0);
    rd(8'h06, rv); chk("R3 reset enable", 32'(rv), 0);
    rd(8'h07, rv); chk("R6 reset ctrl", 32'(rv), 0);
    rst_n = 1'b1;

    set_window(0, 16'h0300, 16'h031F);
    set_window(1, 16'h0310, 16'h03FF);
    rd(8'h09, rv); chk("R1 start hi readback", 32'(rv), 32'h03);
    rd(8'h0E, rv); chk("R1 stop lo readback", 32'(rv), 32'hFF);
    look(16'h0300, 1'b1); chk("R3 no hit before enable", 32'(hit), 0);
    wr(8'h07, 8'hE5);
    wr(8'h06, 8'hFF);
    rd(8'h06, rv); chk("R3 enable readback", 32'(rv), 32'hC0);
    rd(8'h07, rv); chk("R5 nonzero nibbles unchanged", 32'(rv), 32'hE5);

    for (int i = 0; i < 8; i++) begin
      look(VEC[i][21:6], 1'b1);
      // R2 R7 R9 R10 table
      chk($sformatf("R2/R7 vec%0d hit", i), 32'(hit), 32'(VEC[i][5]));
      chk($sformatf("R7 vec%0d win", i), 32'(hit_win), 32'(VEC[i][4]));
      chk($sformatf("R10 vec%0d wide", i), 32'(hit_wide), 32'(VEC[i][3]));
      chk($sformatf("R10 vec%0d card", i), 32'(hit_card_cs), 32'(VEC[i][2]));
      chk($sformatf("R9 vec%0d wait", i), 32'(hit_wait), 32'(VEC[i][1:0]));
    end

    // R8: unstrobed address gives nothing
    look(16'h0300, 1'b0);
    chk("R8 no strobe hit", 32'(hit), 0);
    chk("R8 no strobe wait", 32'(hit_wait), 0);

    // R8: latency, one edge after the strobe
    @(negedge clk);
    addr = 16'h0320; addr_vld = 1'b1;
    #1 chk("R8 not before edge", 32'(hit), 0);
    @(negedge clk);
    addr_vld = 1'b0;
    chk("R8 after one edge", 32'(hit), 1);

    // R4: disable window 1
    wr(8'h06, 8'h40);
    rd(8'h0C, rv); chk("R4 start cleared", 32'(rv), 0);
    rd(8'h0F, rv); chk("R4 stop cleared", 32'(rv), 0);
    look(16'h0320, 1'b1); chk("R3 disabled miss", 32'(hit), 0);
    look(16'h0300, 1'b1); chk("R3 window0 still hits", 32'(hit), 1);

    // R5/R6: default load on window 0, window 1 nibble kept
    wr(8'h06, 8'h00);
    rd(8'h08, rv); chk("R4 win0 start cleared", 32'(rv), 0);
    wr(8'h07, 8'h50);
    wr(8'h06, 8'hC0);
    rd(8'h07, rv); chk("R5/R6 default nibble, other kept", 32'(rv), 32'h5B);
    set_window(0, 16'h1000, 16'h1000);
    look(16'h1000, 1'b1);
    chk("R2 single address hit", 32'(hit), 1);
    chk("R10 default wide", 32'(hit_wide), 1);
    chk("R10 default card", 32'(hit_card_cs), 1);
    chk("R9 default wait", 32'(hit_wait), 32'h2);
    look(16'h1001, 1'b1); chk("R2 just above stop", 32'(hit), 0);
    look(16'h0FFF, 1'b1); chk("R2 just below start", 32'(hit), 0);

    // R9: both wait bits set resolves to extra wait
    wr(8'h07, 8'h5C);
    look(16'h1000, 1'b1);
    chk("R9 both bits", 32'(hit_wait), 32'h2);
    chk("R10 narrow", 32'(hit_wide), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule